// File: doc/BRIEF.md
# ROM integrity check sequencer

This block is the control state machine behind a boot-time ROM integrity check. After reset it lets an address counter stream the lower ROM words to an external hash engine. Next it walks the top ROM words, which hold the expected digest, while the hash engine finishes. When both sides are finished it starts a digest comparator. It then waits for the comparator to report completion and holds a done flag. The counter, the hash engine and the comparator are separate blocks. This block only sees their status flags and drives their control inputs.

The path to the hash engine is a valid/ready stream. Valid is high while the block is in the low-word phase and the counter presents a word. It stays high, with the same word held, until ready is seen. The counter is allowed to step only on an accepted transfer. The hash engine may hold ready low for any number of cycles, and nothing is lost. Once the low phase ends, valid never rises again.

Either the hash engine or the ROM walk may finish first, and both orders lead to the compare. Any event that arrives in a state where it cannot legally happen raises the alert at once. It also forces a sticky invalid state that lasts until the next reset. The state register uses a sparse encoding, and any code outside the legal set decodes as invalid.

Top module: `rom_check_seq`

## Requirements
- R1: After reset the block is in the low-word phase: done_o, alert_o and cmp_start_o are 0, cnt_step_o and dig_cap_o are 0 while ready and read request are 0, and hash_vld_o follows cnt_rd_req_i.
- R2: hash_vld_o is high only in the low-word phase with cnt_rd_req_i high. hash_last_o is high only together with hash_vld_o and cnt_last_low_i. In that phase cnt_step_o is high exactly on a transfer (hash_vld_o and hash_rdy_i).
- R3: The low-word phase ends only on a cycle where the last low word is transferred (cnt_last_low_i, hash_vld_o and hash_rdy_i all high). After that the block enters the top-word phase, in which cnt_step_o is 1 regardless of ready.
- R4: In the top-word phase, counter done alone moves to the ROM-ahead wait. Hash done alone with no error moves to the hash-ahead wait. Both together with no error move to the compare phase.
- R5: Hash done together with hash error, in the top-word phase or in the ROM-ahead wait, moves to invalid.
- R6: The ROM-ahead wait (cnt_step_o follows hash_rdy_i, dig_cap_o is 0) moves to the compare phase on hash done without error.
- R7: The hash-ahead wait (cnt_step_o is 1) moves to the compare phase on counter done.
- R8: cmp_start_o is high for exactly the one cycle whose next state is the compare phase while the current state is not.
- R9: The compare phase moves to done on cmp_done_i, and done_o is then 1.
- R10: An illegal event raises alert_o in the same cycle and forces invalid. The illegal events are comparator done outside the compare and done phases, counter done in the low-word phase, and hash done outside the top-word phase and the ROM-ahead wait.
- R11: alert_o is also high in any cycle where cmp_alert_i or cnt_glitch_i is high. These two inputs alone do not latch it.
- R12: Invalid and done are terminal until reset. Invalid holds alert_o at 1 every cycle. Done ignores further legal counter and comparator done inputs.
- R13: dig_cap_o is 1 in the top-word phase and the hash-ahead wait while cnt_done_i is 0, and 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_rd_req_i | input | 1 | Counter presents a ROM word |
| cnt_last_low_i | input | 1 | Presented word is the last word below the digest |
| cnt_done_i | input | 1 | Counter has walked the whole ROM |
| cnt_step_o | output | 1 | Counter may advance |
| dig_cap_o | output | 1 | Returned word is an expected digest word |
| hash_vld_o | output | 1 | Stream valid toward the hash engine |
| hash_last_o | output | 1 | Current stream word is the last one |
| hash_rdy_i | input | 1 | Hash engine accepts the word |
| hash_done_i | input | 1 | Hash engine finished |
| hash_err_i | input | 1 | Hash engine reports an error |
| cmp_start_o | output | 1 | One-cycle start pulse to the comparator |
| cmp_done_i | input | 1 | Comparator finished |
| cmp_alert_i | input | 1 | Comparator alert |
| cnt_glitch_i | input | 1 | Unexpected counter change detected |
| done_o | output | 1 | Check sequence finished |
| alert_o | output | 1 | Integrity alert |

## Verification
A wrong internal state shows at the ports within one cycle of the transition. The top-word phase drives cnt_step_o high even while ready is low. The ROM-ahead wait drops both step and capture. The hash-ahead wait keeps capturing, and invalid holds alert_o. The bench therefore identifies each state directly from those pins, without waiting for later effects. It sweeps every combination of hash done, counter done and error in the top-word phase, and it injects each illegal event from several states.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned StW = 6;

  // sparse codes, pairwise Hamming distance of two or more
  typedef enum logic [StW-1:0] {
    ST_RD_LOW  = 6'b000111,
    ST_RD_HIGH = 6'b011001,
    ST_ROM_AHD = 6'b101010,
    ST_HSH_AHD = 6'b110100,
    ST_CHECK   = 6'b111111,
    ST_DONE    = 6'b011110,
    ST_INVALID = 6'b100001
  } rcs_state_e;
endpackage

// File: rtl/rcs_state_reg.sv
module rcs_state_reg
  import rcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rcs_state_e next_i,
  output rcs_state_e cur_o
);
  logic [StW-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= ST_RD_LOW;
    else         raw_q <= next_i;
  end

  // any code outside the legal set is treated as invalid
  always_comb begin
    unique case (raw_q)
      ST_RD_LOW:  cur_o = ST_RD_LOW;
      ST_RD_HIGH: cur_o = ST_RD_HIGH;
      ST_ROM_AHD: cur_o = ST_ROM_AHD;
      ST_HSH_AHD: cur_o = ST_HSH_AHD;
      ST_CHECK:   cur_o = ST_CHECK;
      ST_DONE:    cur_o = ST_DONE;
      default:    cur_o = ST_INVALID;
    endcase
  end

  // R12
  invalid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_o == ST_INVALID |=> cur_o == ST_INVALID);
endmodule

// File: rtl/rcs_next.sv
module rcs_next
  import rcs_pkg::*;
(
  input  rcs_state_e state_i,
  input  logic       cnt_last_low_i,
  input  logic       cnt_done_i,
  input  logic       hash_vld_i,
  input  logic       hash_rdy_i,
  input  logic       hash_done_i,
  input  logic       hash_err_i,
  input  logic       cmp_done_i,
  output rcs_state_e next_o,
  output logic       fsm_alert_o
);
  logic ev_cmp, ev_cnt, ev_hash, illegal;
  rcs_state_e nxt;

  always_comb begin
    ev_cmp  = cmp_done_i  && !(state_i inside {ST_CHECK, ST_DONE});
    ev_cnt  = cnt_done_i  && (state_i == ST_RD_LOW);
    ev_hash = hash_done_i && !(state_i inside {ST_RD_HIGH, ST_ROM_AHD});
    illegal = ev_cmp || ev_cnt || ev_hash;
  end

  always_comb begin
    nxt = state_i;
    unique case (state_i)
      ST_RD_LOW: begin
        if (cnt_last_low_i && hash_vld_i && hash_rdy_i) nxt = ST_RD_HIGH;
      end
      ST_RD_HIGH: begin
        unique case ({hash_done_i, cnt_done_i})
          2'b01:   nxt = ST_ROM_AHD;
          2'b10:   nxt = hash_err_i ? ST_INVALID : ST_HSH_AHD;
          2'b11:   nxt = hash_err_i ? ST_INVALID : ST_CHECK;
          default: nxt = ST_RD_HIGH;
        endcase
      end
      ST_ROM_AHD: begin
        if (hash_done_i) nxt = hash_err_i ? ST_INVALID : ST_CHECK;
      end
      ST_HSH_AHD: begin
        if (cnt_done_i) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (cmp_done_i) nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_INVALID;
    endcase
    next_o = illegal ? ST_INVALID : nxt;
  end

  assign fsm_alert_o = illegal || (state_i == ST_INVALID);
endmodule

// File: rtl/rcs_stream.sv
module rcs_stream
  import rcs_pkg::*;
(
  input  rcs_state_e state_i,
  input  logic       cnt_rd_req_i,
  input  logic       cnt_last_low_i,
  input  logic       cnt_done_i,
  input  logic       hash_rdy_i,
  output logic       hash_vld_o,
  output logic       hash_last_o,
  output logic       cnt_step_o,
  output logic       dig_cap_o
);
  logic low_ph, top_ph;

  always_comb begin
    low_ph      = (state_i == ST_RD_LOW);
    top_ph      = state_i inside {ST_RD_HIGH, ST_HSH_AHD};
    hash_vld_o  = low_ph && cnt_rd_req_i;
    hash_last_o = hash_vld_o && cnt_last_low_i;
    // low phase: step on transfer; elsewhere ready or top-word walk
    cnt_step_o  = low_ph ? (hash_vld_o && hash_rdy_i) : (hash_rdy_i || top_ph);
    dig_cap_o   = top_ph && !cnt_done_i;
  end
endmodule

// File: rtl/rom_check_seq.sv
module rom_check_seq
  import rcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_rd_req_i,
  input  logic cnt_last_low_i,
  input  logic cnt_done_i,
  output logic cnt_step_o,
  output logic dig_cap_o,
  output logic hash_vld_o,
  output logic hash_last_o,
  input  logic hash_rdy_i,
  input  logic hash_done_i,
  input  logic hash_err_i,
  output logic cmp_start_o,
  input  logic cmp_done_i,
  input  logic cmp_alert_i,
  input  logic cnt_glitch_i,
  output logic done_o,
  output logic alert_o
);
  rcs_state_e state_q, state_d;
  logic       fsm_alert;

  rcs_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .next_i (state_d),
    .cur_o  (state_q)
  );

  rcs_stream u_stream (
    .state_i        (state_q),
    .cnt_rd_req_i   (cnt_rd_req_i),
    .cnt_last_low_i (cnt_last_low_i),
    .cnt_done_i     (cnt_done_i),
    .hash_rdy_i     (hash_rdy_i),
    .hash_vld_o     (hash_vld_o),
    .hash_last_o    (hash_last_o),
    .cnt_step_o     (cnt_step_o),
    .dig_cap_o      (dig_cap_o)
  );

  rcs_next u_next (
    .state_i        (state_q),
    .cnt_last_low_i (cnt_last_low_i),
    .cnt_done_i     (cnt_done_i),
    .hash_vld_i     (hash_vld_o),
    .hash_rdy_i     (hash_rdy_i),
    .hash_done_i    (hash_done_i),
    .hash_err_i     (hash_err_i),
    .cmp_done_i     (cmp_done_i),
    .next_o         (state_d),
    .fsm_alert_o    (fsm_alert)
  );

  assign cmp_start_o = (state_d == ST_CHECK) && (state_q != ST_CHECK);
  assign done_o      = (state_q == ST_DONE);
  assign alert_o     = fsm_alert || cmp_alert_i || cnt_glitch_i;

  // R3
  low_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_LOW && state_d == ST_RD_HIGH) |-> (hash_vld_o && hash_rdy_i && cnt_last_low_i));
  // R8
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_start_o |=> !cmp_start_o);
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o || alert_o));
  // R10
  invalid_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INVALID) |-> alert_o);
endmodule

// File: tb/tb_rom_check_seq.sv
module tb_rom_check_seq;
  logic clk = 0, rst_n = 0;
  logic rd, last, cdone, rdy, hdone, herr, cmpd, cal, glt;
  logic step, cap, vld, hlast, start, done, alert;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rom_check_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_rd_req_i(rd), .cnt_last_low_i(last),
    .cnt_done_i(cdone), .cnt_step_o(step), .dig_cap_o(cap), .hash_vld_o(vld),
    .hash_last_o(hlast), .hash_rdy_i(rdy), .hash_done_i(hdone), .hash_err_i(herr),
    .cmp_start_o(start), .cmp_done_i(cmpd), .cmp_alert_i(cal), .cnt_glitch_i(glt),
    .done_o(done), .alert_o(alert)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    {rd, last, cdone, rdy, hdone, herr, cmpd, cal, glt} = '0;
  endtask

  // drive after negedge, settle, then sample
  task automatic tick();
    @(posedge clk); @(negedge clk); #2;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; clr(); #2;
    @(negedge clk); @(negedge clk); rst_n = 1; #2;
  endtask

  task automatic to_high();
    rd = 1; last = 1; rdy = 1; #1;
    tick(); clr(); #1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr();
    do_reset();
    // R1 reset state
    chk("R1 done", done, 0); chk("R1 alert", alert, 0); chk("R1 start", start, 0);
    chk("R1 step", step, 0); chk("R1 cap", cap, 0); chk("R1 vld", vld, 0);
    // R2 stream with back-pressure
    rd = 1; #1;
    chk("R2 vld", vld, 1); chk("R2 step no rdy", step, 0); chk("R2 last", hlast, 0);
    rdy = 1; #1; chk("R2 step on xfer", step, 1);
    tick(); rdy = 0; last = 1; #1;
    chk("R2 last with vld", hlast, 1);
    // R3 last word not accepted: stays low phase
    tick(); #1; chk("R3 held low", vld, 1); chk("R3 no top step", step, 0);
    rdy = 1; #1; tick(); clr(); #1;
    chk("R3 top phase step", step, 1); chk("R3 no vld", vld, 0); chk("R13 cap", cap, 1);

    // R4 R5 R13 R8: sweep top-word phase over {hash_done,cnt_done,err}
    for (int c = 0; c < 8; c++) begin
      automatic logic h = c[2], d = c[1], e = c[0];
      int cls; // 0 high,1 rom-ahead,2 hash-ahead,3 check,4 invalid
      do_reset(); to_high();
      cls = (h && e) ? 4 : (h && d) ? 3 : h ? 2 : d ? 1 : 0;
      hdone = h; cdone = d; herr = e; #1;
      chk("R13 cap vs cnt_done", cap, !d);
      chk("R8 start on entry", start, cls == 3);
      tick(); clr(); #1;
      chk("R4 step", step, (cls == 0 || cls == 2));
      chk("R5 alert", alert, cls == 4);
      chk("R13 cap", cap, (cls == 0 || cls == 2));
      if (cls == 1) begin
        hdone = 1; #1; chk("R6 start", start, 1);
        tick(); clr(); #1; chk("R8 pulse ends", start, 0);
        cmpd = 1; #1; tick(); clr(); #1; chk("R9 done", done, 1);
      end else if (cls == 2) begin
        cdone = 1; #1; chk("R7 start", start, 1);
        tick(); clr(); #1; chk("R7 in check", step, 0);
        cmpd = 1; #1; tick(); clr(); #1; chk("R9 done", done, 1);
      end else if (cls == 3) begin
        chk("R9 not done yet", done, 0);
        cmpd = 1; #1; tick(); clr(); #1; chk("R9 done", done, 1);
        // R12 done ignores legal inputs
        cmpd = 1; cdone = 1; #1; tick(); clr(); #1;
        chk("R12 done held", done, 1); chk("R12 no alert", alert, 0);
      end else if (cls == 4) begin
        tick(); #1; chk("R12 invalid sticky", alert, 1);
      end
    end

    // R5 error in rom-ahead wait
    do_reset(); to_high(); cdone = 1; #1; tick(); clr(); #1;
    rdy = 1; #1; chk("R6 step follows rdy", step, 1); rdy = 0; #1;
    chk("R6 no step", step, 0);
    hdone = 1; herr = 1; #1; chk("R5 no start", start, 0);
    tick(); clr(); #1; chk("R5 rom-ahead err", alert, 1);

    // R10 illegal events from several states
    for (int k = 0; k < 5; k++) begin
      do_reset();
      if (k >= 3) to_high();
      if (k == 4) begin hdone = 1; cdone = 1; #1; tick(); clr(); #1; end
      case (k)
        0: cdone = 1;
        1: hdone = 1;
        2: cmpd = 1;
        3: cmpd = 1;
        default: hdone = 1;
      endcase
      #1; chk("R10 alert now", alert, 1);
      tick(); clr(); #1; chk("R10 alert held", alert, 1);
      tick(); #1; chk("R12 invalid keeps alert", alert, 1);
      chk("R12 no done", done, 0);
    end

    // R11 external alert sources are passed through, not latched
    do_reset();
    cal = 1; #1; chk("R11 cmp alert", alert, 1);
    tick(); clr(); #1; chk("R11 not latched", alert, 0);
    glt = 1; #1; chk("R11 glitch alert", alert, 1);
    tick(); clr(); #1; chk("R11 glitch not latched", alert, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule